// File: doc/BRIEF.md
# Serial Transmit Section with Status Flags

This block is the sending half of an asynchronous serial port. Software writes characters over a small strobe-based register bus. Each character goes into a transmit queue. With the queue turned off, it goes into a single holding slot instead. A shift engine takes each character and puts it on the line as one low start bit, five to eight data bits (least significant bit first) and one high stop bit. There is no parity. Each bit period lasts a fixed number of pulses from an external baud-tick input. The line rests high when idle.

A status word reports three things: whether the queue (or the holding slot) is empty, whether it is full, and whether the transmitter is busy. The busy indication is set whenever a character waits in storage, even with the port switched off. It stays set until the last stop bit has left the shift register. Two control bits, a port enable and a transmit enable, must both be set for a new character to start. Clearing either of them during a frame lets that frame finish, and then no further character starts.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line output is 1, the status word at offset 0x18 reads 0x90 (storage-empty and receive-empty set, full and busy clear), and the line-control and control registers read 0.
- R2: A frame is one 0 start bit, the data bits least significant first, and one 1 stop bit. Each bit lasts TICKS_PER_BIT (16) baud ticks.
- R3: The word-length field at line-control bits 6:5 selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Data bits above the selected length are not sent.
- R4: With the queue bit (line-control bit 4) set, up to FIFO_DEPTH (16) characters are stored. The full flag (status bit 5) is then set. A write to offset 0x00 while full is dropped, and the stored characters go out in the order they were written.
- R5: With the queue bit clear, storage is one character deep. The full flag is set after one write, and a second write before transmission is dropped.
- R6: The empty flag (status bit 7) describes only the storage. Once the last character has moved into the shift register, empty reads 1 while busy (status bit 3) still reads 1.
- R7: Busy reads 1 whenever storage holds a character, even with the port enable clear. It stays 1 until the stop bit of the last frame is complete.
- R8: A new frame starts only when both the port enable (control bit 0) and the transmit enable (control bit 8) are 1. Otherwise the line stays at 1 and stored characters stay stored.
- R9: Clearing the enables during a frame completes that frame with its stop bit. No further character starts until the enables are set again, and then the held characters are sent.
- R10: A read strobe returns data on the next cycle. The status word is at 0x18 with receive-empty (bit 4) always 1. Line control at 0x2C returns only bits 6:4. Control at 0x30 returns only bits 9, 8 and 0. Any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, 0 when no read was made |
| baud_tick | input | 1 | One-cycle pulse from the external rate generator |
| txd | output | 1 | Serial line output, idle high |

## Verification
The bench attacks the full boundary in both storage modes. A design that accepted the seventeenth character, or the second character in holding mode, would send an extra frame. The bench holds characters with the port disabled and then watches the status word. A design that tied busy to the shift engine alone would report idle with data waiting. A design that tied empty to the shift register would report non-empty during the last frame. It clears the enables in the middle of a frame. A design that halted at once would cut the frame off, and one that ignored the enables would send the next character. A line monitor decodes every frame at all four word lengths, so a wrong bit order, a wrong bit count or a missing stop bit shows up as a data mismatch.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int CHAR_W = 8;
   localparam int WLEN_W = 2;

   // status word bit positions
   localparam int FLG_TXE_BIT = 7;
   localparam int FLG_TXF_BIT = 5;
   localparam int FLG_RXE_BIT = 4;
   localparam int FLG_BSY_BIT = 3;

   // line-control bit positions
   localparam int LCR_WLEN_LO = 5;
   localparam int LCR_FEN_BIT = 4;

   // control bit positions
   localparam int CTL_UEN_BIT = 0;
   localparam int CTL_TEN_BIT = 8;
   localparam int CTL_REN_BIT = 9;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_STOP
   } tx_state_e;

   typedef struct packed {
      logic              uart_en;
      logic              tx_en;
      logic              rx_en;
      logic              fifo_en;
      logic [WLEN_W-1:0] wlen;
   } tx_cfg_t;

   // data bits per character for a word-length code
   function automatic logic [3:0] char_bits(input logic [WLEN_W-1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
   import uart_tx_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFF_DATA = 'h00,
   parameter int OFF_FLAG = 'h18,
   parameter int OFF_LCTL = 'h2C,
   parameter int OFF_CTRL = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              st_empty,
   input  logic              st_full,
   input  logic              st_busy,
   output tx_cfg_t           cfg,
   output logic              push,
   output logic [CHAR_W-1:0] push_char,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);
   localparam logic [ADDR_W-1:0] A_LCTL = ADDR_W'(OFF_LCTL);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

   if (DATA_W < 16) begin : g_bad_data_w
      $error("uart_tx_regs: DATA_W must be at least 16");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("uart_tx_regs: ADDR_W too narrow for the register offsets");
   end
   if (OFF_DATA == OFF_FLAG || OFF_DATA == OFF_LCTL || OFF_DATA == OFF_CTRL ||
       OFF_FLAG == OFF_LCTL || OFF_FLAG == OFF_CTRL || OFF_LCTL == OFF_CTRL) begin : g_bad_map
      $error("uart_tx_regs: register offsets must be distinct");
   end

   tx_cfg_t           cfg_q;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_LCTL) begin
            cfg_q.fifo_en <= bus_wdata[LCR_FEN_BIT];
            cfg_q.wlen    <= bus_wdata[LCR_WLEN_LO +: WLEN_W];
         end
         if (bus_addr == A_CTRL) begin
            cfg_q.uart_en <= bus_wdata[CTL_UEN_BIT];
            cfg_q.tx_en   <= bus_wdata[CTL_TEN_BIT];
            cfg_q.rx_en   <= bus_wdata[CTL_REN_BIT];
         end
      end
   end

   assign push      = bus_wr && (bus_addr == A_DATA);
   assign push_char = bus_wdata[CHAR_W-1:0];
   assign cfg       = cfg_q;

   always_comb begin
      rd_word = '0;
      if (bus_addr == A_FLAG) begin
         rd_word[FLG_TXE_BIT] = st_empty;
         rd_word[FLG_TXF_BIT] = st_full;
         rd_word[FLG_RXE_BIT] = 1'b1;
         rd_word[FLG_BSY_BIT] = st_busy;
      end else if (bus_addr == A_LCTL) begin
         rd_word[LCR_FEN_BIT]               = cfg_q.fifo_en;
         rd_word[LCR_WLEN_LO +: WLEN_W]     = cfg_q.wlen;
      end else if (bus_addr == A_CTRL) begin
         rd_word[CTL_UEN_BIT] = cfg_q.uart_en;
         rd_word[CTL_TEN_BIT] = cfg_q.tx_en;
         rd_word[CTL_REN_BIT] = cfg_q.rx_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else begin
         rdata_q <= bus_rd ? rd_word : '0;
      end
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_tx_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q, cap;
   logic             push_ok, pop_ok;

   // pointer wrap: free for a power-of-two depth, explicit otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   // holding-register mode limits occupancy to one entry
   assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q >= cap);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign count = cnt_q;

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   localparam int TCNT_W = $clog2(TICKS_PER_BIT),
   localparam int BIT_W  = $clog2(CHAR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              can_start,
   input  logic [CHAR_W-1:0] load_char,
   input  logic [WLEN_W-1:0] wlen,
   output logic              pop,
   output logic              active,
   output logic              txd
);

   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("uart_tx_shifter: TICKS_PER_BIT must be at least 2");
   end

   tx_state_e         state;
   logic [TCNT_W-1:0] tcnt;
   logic [CHAR_W-1:0] sh;
   logic [BIT_W-1:0]  bits_left;
   logic              bit_end;

   assign bit_end = baud_tick && (tcnt == TCNT_W'(TICKS_PER_BIT - 1));
   assign pop     = (state == TX_IDLE) && can_start;
   assign active  = (state != TX_IDLE);

   // tick counter within a bit period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt <= '0;
      end else if (state == TX_IDLE) begin
         tcnt <= '0;
      end else if (baud_tick) begin
         tcnt <= bit_end ? '0 : tcnt + TCNT_W'(1);
      end
   end

   // frame sequencing; enables are only consulted in idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         sh        <= '0;
         bits_left <= '0;
      end else begin
         unique case (state)
            TX_IDLE: begin
               if (can_start) begin
                  sh        <= load_char;
                  bits_left <= BIT_W'(char_bits(wlen) - 4'd1);
                  state     <= TX_START;
               end
            end
            TX_START: begin
               if (bit_end) state <= TX_DATA;
            end
            TX_DATA: begin
               if (bit_end) begin
                  if (bits_left == '0) begin
                     state <= TX_STOP;
                  end else begin
                     sh        <= sh >> 1;
                     bits_left <= bits_left - BIT_W'(1);
                  end
               end
            end
            TX_STOP: begin
               if (bit_end) state <= TX_IDLE;
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         TX_START: txd = 1'b0;
         TX_DATA:  txd = sh[0];
         default:  txd = 1'b1;
      endcase
   end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_tx_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int FIFO_DEPTH    = 16,
   parameter int TICKS_PER_BIT = 16,
   parameter int OFF_DATA      = 'h00,
   parameter int OFF_FLAG      = 'h18,
   parameter int OFF_LCTL      = 'h2C,
   parameter int OFF_CTRL      = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              baud_tick,
   output logic              txd
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   tx_cfg_t           cfg;
   logic              push, pop;
   logic [CHAR_W-1:0] push_char, fifo_head;
   logic              fifo_empty, fifo_full;
   logic [CNT_W-1:0]  fifo_count;
   logic              shift_active, can_start, busy;

   assign can_start = !fifo_empty && cfg.uart_en && cfg.tx_en;
   assign busy      = !fifo_empty || shift_active;

   uart_tx_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OFF_DATA (OFF_DATA),
      .OFF_FLAG (OFF_FLAG),
      .OFF_LCTL (OFF_LCTL),
      .OFF_CTRL (OFF_CTRL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .st_empty  (fifo_empty),
      .st_full   (fifo_full),
      .st_busy   (busy),
      .cfg       (cfg),
      .push      (push),
      .push_char (push_char),
      .bus_rdata (bus_rdata)
   );

   uart_tx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (CHAR_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (cfg.fifo_en),
      .push      (push),
      .push_data (push_char),
      .pop       (pop),
      .head      (fifo_head),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .count     (fifo_count)
   );

   uart_tx_shifter #(
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .can_start (can_start),
      .load_char (fifo_head),
      .wlen      (cfg.wlen),
      .pop       (pop),
      .active    (shift_active),
      .txd       (txd)
   );

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
   parameter int FIFO_DEPTH = 16,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txd,
   input logic             busy,
   input logic             fifo_empty,
   input logic             fifo_full,
   input logic [CNT_W-1:0] fifo_count,
   input logic             push,
   input logic             pop,
   input logic             shift_active,
   input logic             uart_en,
   input logic             tx_en,
   input logic             fifo_en
);

   // R7
   busy_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_empty |-> busy);

   // R2
   line_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> busy);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(FIFO_DEPTH));

   // R4
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && push && !pop) |=> $stable(fifo_count));

   // R5
   holding_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && fifo_count != '0 && push && !pop) |=> $stable(fifo_count));

   // R8
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_active && !(uart_en && tx_en)) |=> !shift_active);

   // R9
   frame_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_active) |-> $past(txd));

   // R6
   pop_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> shift_active);

endmodule

bind uart_tx_core uart_tx_core_chk #(
   .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .txd          (txd),
   .busy         (busy),
   .fifo_empty   (fifo_empty),
   .fifo_full    (fifo_full),
   .fifo_count   (fifo_count),
   .push         (push),
   .pop          (pop),
   .shift_active (shift_active),
   .uart_en      (cfg.uart_en),
   .tx_en        (cfg.tx_en),
   .fifo_en      (cfg.fifo_en)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

   localparam int TICK_DIV = 3;
   localparam int DEPTH    = 16;
   localparam int TPB      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        baud_tick = 1'b0;
   logic        txd;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int mon_bits = 8;
   int div = 0;
   logic [7:0] rx_q[$];
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         div       <= 0;
         baud_tick <= 1'b0;
      end else begin
         div       <= (div == TICK_DIV - 1) ? 0 : div + 1;
         baud_tick <= (div == TICK_DIV - 1);
      end
   end

   uart_tx_core #(.FIFO_DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .baud_tick (baud_tick),
      .txd       (txd)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] flags(bit e, bit f, bit b);
      logic [31:0] w = '0;
      w[7] = e; w[5] = f; w[4] = 1'b1; w[3] = b;
      return w;
   endfunction

   function automatic logic [7:0] mask_char(logic [7:0] c, int bits);
      return c & 8'((1 << bits) - 1);
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_ticks(input int n);
      int k = 0;
      while (k < n) begin
         @(negedge clk);
         if (baud_tick) k++;
      end
   endtask

   task automatic wait_txd_low();
      int k = 0;
      while (txd !== 1'b0 && k < 5000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic wait_drain();
      logic [31:0] f;
      int k = 0;
      bus_read(8'h18, f);
      while (f[3] && k < 20000) begin
         bus_read(8'h18, f);
         k++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic compare_frames(input string req);
      check(req, "frame count", rx_q.size(), exp_q.size());
      while (exp_q.size() > 0 && rx_q.size() > 0)
         check(req, "frame data", rx_q.pop_front(), exp_q.pop_front());
      exp_q.delete();
      rx_q.delete();
   endtask

   task automatic set_line(input int wl, input bit fen);
      mon_bits = 5 + wl;
      bus_write(8'h2C, (32'(wl) << 5) | (32'(fen) << 4));
   endtask

   // line monitor: decodes frames at mid-bit (R2, R3)
   initial begin
      logic [7:0] v;
      logic       s;
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            v = '0;
            wait_ticks(TPB / 2);
            s = txd;
            for (int i = 0; i < mon_bits; i++) begin
               wait_ticks(TPB);
               v[i] = txd;
            end
            wait_ticks(TPB);
            check("R2", "start bit", 32'(s), 32'd0);
            check("R2", "stop bit", 32'(txd), 32'd1);
            rx_q.push_back(v);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1..all watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [7:0]  c;
      int          lows;
      void'($urandom(32'd5150));

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "txd idle", 32'(txd), 32'd1);
      bus_read(8'h18, r); check("R1", "status", r, 32'h90);
      bus_read(8'h2C, r); check("R1", "line ctl", r, 32'h0);
      bus_read(8'h30, r); check("R1", "control", r, 32'h0);

      // R10 register access
      bus_write(8'h2C, 32'hFFFF_FFFF);
      bus_read(8'h2C, r); check("R10", "line ctl readback", r, 32'h70);
      bus_write(8'h30, 32'hFFFF_FFFF);
      bus_read(8'h30, r); check("R10", "control readback", r, 32'h301);
      bus_read(8'h04, r); check("R10", "unmapped read", r, 32'h0);
      bus_read(8'h00, r); check("R10", "data offset reads zero", r, 32'h0);
      bus_write(8'h30, 32'h0);
      set_line(3, 1'b1);

      // R7 / R8: stored while disabled
      bus_write(8'h00, 32'hA5);
      bus_read(8'h18, r); check("R7", "busy while disabled", r, flags(0, 0, 1));
      lows = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R8", "line idle both off", lows, 0);
      bus_write(8'h30, 32'h100);
      lows = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R8", "line idle tx only", lows, 0);
      bus_write(8'h30, 32'h001);
      lows = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R8", "line idle uart only", lows, 0);
      bus_read(8'h18, r); check("R8", "still stored", r, flags(0, 0, 1));
      bus_write(8'h30, 32'h101);
      exp_q.push_back(8'hA5);
      wait_txd_low();
      // R6: shifter loaded, storage empty, still busy
      bus_read(8'h18, r); check("R6", "empty while shifting", r, flags(1, 0, 1));
      wait_drain();
      bus_read(8'h18, r); check("R7", "busy clears after stop", r, flags(1, 0, 0));
      compare_frames("R2");

      // R5 holding-register mode
      bus_write(8'h30, 32'h0);
      set_line(3, 1'b0);
      bus_write(8'h00, 32'h11);
      bus_read(8'h18, r); check("R5", "holding full", r, flags(0, 1, 1));
      bus_write(8'h00, 32'h22);
      bus_write(8'h30, 32'h101);
      exp_q.push_back(8'h11);
      wait_drain();
      compare_frames("R5");

      // R4 queue full and drop
      bus_write(8'h30, 32'h0);
      set_line(3, 1'b1);
      for (int i = 0; i < DEPTH + 2; i++) begin
         bus_write(8'h00, 32'(8'h40 + i));
         if (i < DEPTH) exp_q.push_back(8'(8'h40 + i));
      end
      bus_read(8'h18, r); check("R4", "queue full", r, flags(0, 1, 1));
      bus_write(8'h30, 32'h101);
      wait_drain();
      compare_frames("R4");

      // R3 each word length
      for (int wl = 0; wl < 4; wl++) begin
         set_line(wl, 1'b1);
         c = 8'hE6 ^ 8'(wl);
         exp_q.push_back(mask_char(c, 5 + wl));
         bus_write(8'h00, 32'(c));
         wait_drain();
         compare_frames("R3");
      end

      // R9 disable mid-frame
      bus_write(8'h30, 32'h0);
      set_line(3, 1'b1);
      bus_write(8'h00, 32'h3C);
      bus_write(8'h00, 32'hC3);
      bus_write(8'h30, 32'h101);
      wait_txd_low();
      bus_write(8'h30, 32'h0);
      exp_q.push_back(8'h3C);
      repeat (TPB * TICK_DIV * 15) @(negedge clk);
      compare_frames("R9");
      bus_read(8'h18, r); check("R9", "second held", r, flags(0, 0, 1));
      check("R9", "line idle", 32'(txd), 32'd1);
      bus_write(8'h30, 32'h301);
      exp_q.push_back(8'hC3);
      wait_drain();
      compare_frames("R9");

      // random rounds (R4, R5, R3)
      for (int rnd = 0; rnd < 6; rnd++) begin
         int  wl, cap, n;
         bit  fen;
         fen = 1'($urandom % 2);
         wl  = int'($urandom % 4);
         cap = fen ? DEPTH : 1;
         n   = 1 + int'($urandom % (cap + 3));
         bus_write(8'h30, 32'h0);
         set_line(wl, fen);
         for (int i = 0; i < n; i++) begin
            c = 8'($urandom);
            bus_write(8'h00, 32'(c));
            if (i < cap) exp_q.push_back(mask_char(c, 5 + wl));
         end
         bus_read(8'h18, r);
         check(fen ? "R4" : "R5", "random status", r, flags(0, n >= cap, 1));
         bus_write(8'h30, 32'h101);
         wait_drain();
         compare_frames(fen ? "R4" : "R5");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule